// File: doc/BRIEF.md
# Segment Overflow Address Checker

This block forms the effective address in the address-generation stage of a load/store unit. It adds a sign-extended 16-bit displacement to a 64-bit base value, then registers the sum, so the result appears one cycle after an input strobe.

When the tags-active mode bit is set, the block flags an exception if the sum lies in a different aligned 16 MiB segment than the base. A segment is the address with bits 63:24 kept and the 24-bit offset dropped. A base whose top 16 bits are all zero is exempt from the check, which means any address below 256 TiB is never flagged. With the mode bit clear, the block is a plain adder. Address translation, the memory access and the delivery of the exception happen elsewhere.

Top module: `seg_addr_check`

## Requirements
- R1: While reset is held and on the first edge after it, `out_valid` and `out_fault` are 0.
- R2: `out_valid` equals the value `in_valid` had on the previous clock edge.
- R3: One cycle after an accepted input, `out_addr` equals `in_base` plus `in_disp` sign-extended from bit 15, modulo 2^64.
- R4: When `in_tags_on` is 0, `out_fault` is 0 for that input, whatever the base and displacement.
- R5: When `in_tags_on` is 1 and bits 63:48 of the base are not all zero, `out_fault` is 1 exactly when bits 63:24 of the sum differ from bits 63:24 of the base.
- R6: When bits 63:48 of the base are all zero, `out_fault` is 0, even if the sum crosses a 16 MiB boundary or crosses 2^48.
- R7: When the sum stays in the base's 16 MiB segment, `out_fault` is 0 in both modes.
- R8: A sum that wraps past 2^64 counts as a segment change and raises `out_fault` when the check applies.
- R9: `out_fault` is 0 in every cycle in which `out_valid` is 0.
- R10: `out_addr` keeps its value in cycles that follow a cycle with `in_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe |
| in_base | input | 64 | Base register value |
| in_disp | input | 16 | Signed displacement |
| in_tags_on | input | 1 | Tags-active mode; enables the segment check |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_addr | output | 64 | Effective address |
| out_fault | output | 1 | Segment-overflow exception, qualified by `out_valid` |

## Verification
The hard cases are sums that fall within a few bytes of a 16 MiB boundary, of 2^48 or of 2^64. A 16-bit displacement reaches only a small window, so a random 64-bit base almost never lands near a boundary. The bench therefore places each base a short distance below or above such a boundary. It then sweeps the full signed displacement range in coarse steps, adds the extreme values, and runs every pair in both modes. This reaches the upward crossings, the downward borrows, the 2^64 wrap and the crossings in the exempt region, with the exact first and last displacement that cross.

// File: rtl/seg_addr_check.sv
module seg_addr_check #(
  parameter int ADDR_W   = 64,
  parameter int DISP_W   = 16,
  parameter int EXEMPT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [DISP_W-1:0] in_disp,
  input  logic              in_tags_on,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_fault
);
  localparam int SEG_SHIFT = 24;
  localparam int EXT_W     = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] sum;
  logic              exempt;
  logic              seg_moved;
  logic              fault_d;

  assign disp_ext  = {{EXT_W{in_disp[DISP_W-1]}}, in_disp};
  assign sum       = in_base + disp_ext;
  assign exempt    = (in_base[ADDR_W-1 -: EXEMPT_W] == '0);
  assign seg_moved = (sum[ADDR_W-1:SEG_SHIFT] != in_base[ADDR_W-1:SEG_SHIFT]);
  assign fault_d   = in_tags_on & ~exempt & seg_moved;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      out_fault <= in_valid & fault_d;
      if (in_valid) out_addr <= sum;
    end
  end
endmodule

// File: rtl/seg_addr_check_sva.sv
module seg_addr_check_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] in_base,
  input logic [15:0] in_disp,
  input logic        in_tags_on,
  input logic        out_valid,
  input logic [63:0] out_addr,
  input logic        out_fault
);
  logic unused_disp;
  assign unused_disp = ^in_disp;

  assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_strobe_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_no_fault_inactive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_tags_on) |=> !out_fault);
  assert_fault_on_segment_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_tags_on && (in_base[63:48] != 16'h0)) |=>
      (out_fault == (out_addr[63:24] != $past(in_base[63:24]))));
  assert_no_fault_exempt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_base[63:48] == 16'h0)) |=> !out_fault);
  assert_fault_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_fault);
  assert_addr_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_addr));
endmodule

bind seg_addr_check seg_addr_check_sva u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_base(in_base),
  .in_disp(in_disp), .in_tags_on(in_tags_on), .out_valid(out_valid),
  .out_addr(out_addr), .out_fault(out_fault)
);

// File: tb/seg_addr_check_bench.sv
module seg_addr_check_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_base = '0;
  logic [15:0] in_disp = '0;
  logic        in_tags_on = 1'b0;
  logic        out_valid;
  logic [63:0] out_addr;
  logic        out_fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  seg_addr_check u_seg_addr_check (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_base(in_base),
    .in_disp(in_disp), .in_tags_on(in_tags_on), .out_valid(out_valid),
    .out_addr(out_addr), .out_fault(out_fault)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [63:0] base, input logic [15:0] disp, input logic tags);
    logic [63:0] exp_addr;
    logic        wrap;
    logic        exp_fault;
    string       req;
    exp_addr  = base + {{48{disp[15]}}, disp};
    wrap      = disp[15] ? (exp_addr > base) : (exp_addr < base);
    exp_fault = tags && (base[63:48] != 16'h0) && (exp_addr[63:24] != base[63:24]);
    if (!tags) req = "R4";
    else if (base[63:48] == 16'h0) req = "R6";
    else if (wrap) req = "R8";
    else if (exp_fault) req = "R5";
    else req = "R7";
    @(negedge clk);
    in_valid = 1'b1; in_base = base; in_disp = disp; in_tags_on = tags;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", {63'd0, out_valid}, 64'd1);
    check("R3", out_addr, exp_addr);
    check(req, {63'd0, out_fault}, {63'd0, exp_fault});
  endtask

  logic [63:0] bases [10];
  logic [15:0] extras [6];

  initial begin
    bases[0] = 64'h0001_0000_00FF_FFF0;
    bases[1] = 64'h0001_0000_0100_0010;
    bases[2] = 64'h8000_0000_00FF_8000;
    bases[3] = 64'hFFFF_FFFF_FFFF_FFF0;
    bases[4] = 64'h0001_0000_0080_0000;
    bases[5] = 64'h0000_1234_56FF_FFF0;
    bases[6] = 64'h0000_FFFF_FFFF_FFF8;
    bases[7] = 64'h0000_0000_0000_0004;
    bases[8] = 64'hFFFF_0000_0000_0008;
    bases[9] = 64'h0001_0000_0000_0000;
    extras[0] = 16'h7FFF; extras[1] = 16'h8000; extras[2] = 16'h0010;
    extras[3] = 16'h000F; extras[4] = 16'hFFF0; extras[5] = 16'hFFEF;

    repeat (3) @(negedge clk);
    check("R1", {62'd0, out_valid, out_fault}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {62'd0, out_valid, out_fault}, 64'd0);

    for (int b = 0; b < 10; b++) begin
      for (int t = 0; t < 2; t++) begin
        for (int i = 0; i < 256; i++) run_vec(bases[b], 16'(i * 257), t[0]);
        for (int e = 0; e < 6; e++) run_vec(bases[b], extras[e], t[0]);
      end
    end

    run_vec(64'hFFFF_FFFF_FFFF_FFF0, 16'h0010, 1'b1);
    in_base = 64'h1234_0000_0000_0000; in_disp = 16'h7FFF; in_tags_on = 1'b1;
    @(negedge clk);
    check("R9", {62'd0, out_valid, out_fault}, 64'd0);
    check("R10", out_addr, 64'h0);
    @(negedge clk);
    check("R10", out_addr, 64'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule